// File: doc/BRIEF.md
# Power-Good Reset Sequencer

This block turns a single raw power-good level into an ordered set of platform reset and status outputs. It filters the power-good input, keeps the host-bus, peripheral-bus and processor-link resets (all active low) asserted while power is not good, and once power-good has been steady long enough it releases them in a fixed order. The order is host-bus reset first, then peripheral-bus reset, then processor-link reset. It also raises a delayed bridge power-ok output. The processor-stop and sleep outputs follow the same sequence.

On loss of power-good, the host-bus and peripheral-bus resets, the bridge power-ok and the processor-stop are all taken down together. The processor-link reset follows after a lead time, and the sleep output drops after a further lag. A keyboard-reset input can hold the host-bus reset, and with it the rest of the release sequence. Every delay is a parameter counted in clock cycles, so a fast simulation clock can stand in for real time.

A static reset-length select chooses between a long and a short power-up reset. It is sampled when the debounced power-good rises. There is no data stream, so every pin is a plain level.

Top module: `pwr_rst_seq`

## Requirements
- R1: The internal debounced power-good rises only after `pg_raw` has been high for DEB_CYC consecutive cycles. Any low cycle restarts the count, so all power-up timing is measured from the last rising edge of `pg_raw`, and a high pulse shorter than DEB_CYC changes no output.
- R2: Within 5 cycles of `pg_raw` falling, `host_rst_n` and `pbus_rst_n` are 0. They stay 0 until the next completed power-up sequence.
- R3: The resets release in a fixed order. `pbus_rst_n` rises HOST_TO_PB cycles after `host_rst_n`, and `link_rst_n` rises PB_TO_LINK cycles after `pbus_rst_n`.
- R4: With `rst_len_short` = 0 (long reset), `pbus_rst_n` rises DEB_CYC+PB_LONG cycles after the last rise of `pg_raw`, plus at most 5 cycles of pipeline latency. With `rst_len_short` = 1 the delay uses PB_SHORT instead.
- R5: `bridge_pok` rises DEB_CYC+NB_DLY cycles after the last rise of `pg_raw`, plus at most 5 cycles. It falls within 5 cycles of `pg_raw` falling.
- R6: While `kbd_rst_n` is 0, `host_rst_n` stays 0 even after its delay has elapsed. It rises within 5 cycles of `kbd_rst_n` going to 1, and the rest of the order in R3 follows from that release.
- R7: On power loss from the running state, `cpu_stop_n` falls together with the bus resets. `link_rst_n` falls STOP_LEAD cycles later, and `sleep_n` falls SLP_LAG cycles after that.
- R8: During and right after `rst_n`, all six outputs are 0. Each output is a register, and every transition of every output happens exactly once, at the point that R3 to R9 define, with no extra toggles.
- R9: `sleep_n` rises when the debounced power-good rises. `cpu_stop_n` rises in the same cycle as `link_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| pg_raw | input | 1 | Raw power-good level, asynchronous |
| kbd_rst_n | input | 1 | Keyboard reset, active low, asynchronous |
| rst_len_short | input | 1 | Static select: 0 selects the long reset, 1 the short reset |
| host_rst_n | output | 1 | Host-bus reset, active low |
| pbus_rst_n | output | 1 | Peripheral-bus reset, active low |
| link_rst_n | output | 1 | Processor-link reset, active low |
| bridge_pok | output | 1 | Delayed power-ok to the bridge, active high |
| cpu_stop_n | output | 1 | Processor stop, active low |
| sleep_n | output | 1 | Sleep output, active low |

## Verification
Power-up is driven with the long select and with the short select. The two runs separate the two PB delays, and the position of each release inside its window shows that the counters load the right values. A high pulse shorter than the filter window, followed by a steady rise, shows whether the timing is measured from the last rising edge rather than the first. A keyboard reset held past the release point shows whether the host-bus reset waits and whether the later resets shift with it. Every power-down is expected to produce the stop, link-reset and sleep edges in that order, so any missing, early or extra edge on any output is caught.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HOST = 3'd1,
    ST_PBUS = 3'd2,
    ST_LINK = 3'd3,
    ST_ON   = 3'd4,
    ST_STOP = 3'd5,
    ST_SLP  = 3'd6
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_up(input seq_state_e s);
    return (s == ST_HOST) || (s == ST_PBUS) || (s == ST_LINK) || (s == ST_ON);
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pgood_debounce.sv
module pgood_debounce #(
  parameter int DEB_CYC = 16,
  parameter int CW      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_in,
  output logic pg_deb
);
  logic [CW-1:0] run_cnt;
  localparam logic [CW-1:0] RUN_LAST = CW'(DEB_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      pg_deb  <= 1'b0;
    end else if (!pg_in) begin
      run_cnt <= '0;
      pg_deb  <= 1'b0;
    end else if (!pg_deb) begin
      if (run_cnt == RUN_LAST) pg_deb <= 1'b1;
      else                     run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1: a rise needs the input high in the cycle before
  a_r1_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_deb) |-> $past(pg_in));
  // R2: any low input drops the filtered level at the next edge
  a_r2_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_in |=> !pg_deb);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import pwrseq_pkg::*;
#(
  parameter int HOST_TO_PB = 19,
  parameter int PB_LONG    = 100,
  parameter int PB_SHORT   = 40,
  parameter int PB_TO_LINK = 30,
  parameter int NB_DLY     = 10,
  parameter int STOP_LEAD  = 20,
  parameter int SLP_LAG    = 5,
  parameter int CW         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_deb,
  input  logic kbd_ok,
  input  logic len_short,
  output logic host_rst_n,
  output logic pbus_rst_n,
  output logic link_rst_n,
  output logic bridge_pok,
  output logic cpu_stop_n,
  output logic sleep_n
);
  seq_state_e    state, nxt;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] nb_cnt, nb_cnt_n;

  localparam logic [CW-1:0] LD_HOST_L = CW'(PB_LONG  - HOST_TO_PB - 1);
  localparam logic [CW-1:0] LD_HOST_S = CW'(PB_SHORT - HOST_TO_PB - 1);
  localparam logic [CW-1:0] LD_PBUS   = CW'(HOST_TO_PB - 1);
  localparam logic [CW-1:0] LD_LINK   = CW'(PB_TO_LINK - 1);
  localparam logic [CW-1:0] LD_STOP   = CW'(STOP_LEAD - 1);
  localparam logic [CW-1:0] LD_SLP    = CW'(SLP_LAG - 1);
  localparam logic [CW-1:0] LD_NB     = CW'(NB_DLY - 1);

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    unique case (state)
      ST_OFF: if (pg_deb) begin
        nxt   = ST_HOST;
        cnt_n = len_short ? LD_HOST_S : LD_HOST_L;
      end
      ST_HOST: begin
        if (!pg_deb) begin
          nxt = ST_STOP; cnt_n = LD_STOP;
        end else if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (kbd_ok) begin
          nxt = ST_PBUS; cnt_n = LD_PBUS;
        end
      end
      ST_PBUS: begin
        if (!pg_deb) begin
          nxt = ST_STOP; cnt_n = LD_STOP;
        end else if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else begin
          nxt = ST_LINK; cnt_n = LD_LINK;
        end
      end
      ST_LINK: begin
        if (!pg_deb) begin
          nxt = ST_STOP; cnt_n = LD_STOP;
        end else if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else begin
          nxt = ST_ON;
        end
      end
      ST_ON: if (!pg_deb) begin
        nxt = ST_STOP; cnt_n = LD_STOP;
      end
      ST_STOP: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else begin
          nxt = ST_SLP; cnt_n = LD_SLP;
        end
      end
      ST_SLP: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else           nxt = ST_OFF;
      end
      default: nxt = ST_OFF;
    endcase
  end

  // bridge power-ok timer runs from entry into the power-up states
  always_comb begin
    if (!is_up(nxt))           nb_cnt_n = LD_NB;
    else if (!is_up(state))    nb_cnt_n = LD_NB;
    else if (nb_cnt != '0)     nb_cnt_n = nb_cnt - 1'b1;
    else                       nb_cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      cnt        <= '0;
      nb_cnt     <= LD_NB;
      host_rst_n <= 1'b0;
      pbus_rst_n <= 1'b0;
      link_rst_n <= 1'b0;
      bridge_pok <= 1'b0;
      cpu_stop_n <= 1'b0;
      sleep_n    <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= cnt_n;
      nb_cnt     <= nb_cnt_n;
      host_rst_n <= (nxt == ST_PBUS) || (nxt == ST_LINK) || (nxt == ST_ON);
      pbus_rst_n <= (nxt == ST_LINK) || (nxt == ST_ON);
      link_rst_n <= (nxt == ST_ON) || ((nxt == ST_STOP) && link_rst_n);
      bridge_pok <= is_up(nxt) && (nb_cnt_n == '0);
      cpu_stop_n <= (nxt == ST_ON);
      sleep_n    <= (nxt != ST_OFF);
    end
  end

  // R2: host reset asserted one edge after filtered power-good is low
  a_r2_host_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_deb |=> !host_rst_n);
  // R3: ordering of the releases
  a_r3_pbus_after_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pbus_rst_n) |-> host_rst_n && $past(host_rst_n));
  a_r3_link_after_pbus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rst_n) |-> pbus_rst_n && $past(pbus_rst_n));
  // R5: bridge power-ok follows a filtered fall at once
  a_r5_pok_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_deb) |=> !bridge_pok);
  // R6: keyboard reset keeps the host reset held
  a_r6_kbd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_ok && !host_rst_n) |=> !host_rst_n);
  // R7: stop leads the link reset, sleep trails it
  a_r7_stop_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_rst_n) |-> !cpu_stop_n && $past(!cpu_stop_n));
  a_r7_sleep_trails: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_n) |-> !link_rst_n);
  // R9: stop releases with the link reset
  a_r9_stop_with_link: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stop_n) |-> $rose(link_rst_n));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwrseq_pkg::*;
#(
  parameter int DEB_CYC    = 2_500_000,
  parameter int HOST_TO_PB = 19,
  parameter int PB_LONG    = 26_750_000,
  parameter int PB_SHORT   = 625_000,
  parameter int PB_TO_LINK = 400_000,
  parameter int NB_DLY     = 250,
  parameter int STOP_LEAD  = 10_000,
  parameter int SLP_LAG    = 1_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_raw,
  input  logic kbd_rst_n,
  input  logic rst_len_short,
  output logic host_rst_n,
  output logic pbus_rst_n,
  output logic link_rst_n,
  output logic bridge_pok,
  output logic cpu_stop_n,
  output logic sleep_n
);
  localparam int MAXD = max2(max2(max2(DEB_CYC, PB_LONG), max2(PB_SHORT, PB_TO_LINK)),
                             max2(max2(NB_DLY, STOP_LEAD), max2(SLP_LAG, HOST_TO_PB)));
  localparam int CW = $clog2(MAXD + 1);

  logic pg_s, kbd_s, pg_deb;

  bit_sync #(.RST_VAL(1'b0)) u_pg_sync  (.clk(clk), .rst_n(rst_n), .d(pg_raw),    .q(pg_s));
  bit_sync #(.RST_VAL(1'b0)) u_kbd_sync (.clk(clk), .rst_n(rst_n), .d(kbd_rst_n), .q(kbd_s));

  pgood_debounce #(.DEB_CYC(DEB_CYC), .CW(CW)) u_deb (
    .clk(clk), .rst_n(rst_n), .pg_in(pg_s), .pg_deb(pg_deb)
  );

  rst_seq_fsm #(
    .HOST_TO_PB(HOST_TO_PB), .PB_LONG(PB_LONG), .PB_SHORT(PB_SHORT),
    .PB_TO_LINK(PB_TO_LINK), .NB_DLY(NB_DLY), .STOP_LEAD(STOP_LEAD),
    .SLP_LAG(SLP_LAG), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pg_deb(pg_deb), .kbd_ok(kbd_s),
    .len_short(rst_len_short),
    .host_rst_n(host_rst_n), .pbus_rst_n(pbus_rst_n), .link_rst_n(link_rst_n),
    .bridge_pok(bridge_pok), .cpu_stop_n(cpu_stop_n), .sleep_n(sleep_n)
  );

  initial begin
    assert (PB_SHORT > HOST_TO_PB && PB_LONG > HOST_TO_PB && HOST_TO_PB >= 1 &&
            NB_DLY >= 1 && STOP_LEAD >= 1 && SLP_LAG >= 1 && PB_TO_LINK >= 1 && DEB_CYC >= 1)
      else $error("pwr_rst_seq: delay parameters out of range");
  end
endmodule

// File: tb/sim_pwr_rst_seq.sv
module sim_pwr_rst_seq;
  localparam int DEB = 40, H = 5, PBL = 200, PBS = 80, PL = 30, NB = 20, SL = 25, SG = 6;
  localparam int TOL = 5;

  logic clk = 1'b0, rst_n = 1'b0, pg_raw = 1'b0, kbd_rst_n = 1'b1, rst_len_short = 1'b0;
  logic host_rst_n, pbus_rst_n, link_rst_n, bridge_pok, cpu_stop_n, sleep_n;
  int cyc = 0, total = 0, bad = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_rst_seq #(.DEB_CYC(DEB), .HOST_TO_PB(H), .PB_LONG(PBL), .PB_SHORT(PBS),
    .PB_TO_LINK(PL), .NB_DLY(NB), .STOP_LEAD(SL), .SLP_LAG(SG)) u0 (
    .clk(clk), .rst_n(rst_n), .pg_raw(pg_raw), .kbd_rst_n(kbd_rst_n),
    .rst_len_short(rst_len_short), .host_rst_n(host_rst_n), .pbus_rst_n(pbus_rst_n),
    .link_rst_n(link_rst_n), .bridge_pok(bridge_pok), .cpu_stop_n(cpu_stop_n),
    .sleep_n(sleep_n));

  // output index: 0 host, 1 pbus, 2 link, 3 bridge_pok, 4 stop, 5 sleep
  typedef struct { int idx; bit val; int lo; int hi; string tag; } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_edge(input int idx, input bit val, input int lo, input string tag);
    exp_t e;
    e.idx = idx; e.val = val; e.lo = lo; e.hi = lo + TOL; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: every output edge must match the front of the queue
  logic [5:0] prev;
  always @(negedge clk) begin
    logic [5:0] cur;
    cur = {sleep_n, cpu_stop_n, bridge_pok, link_rst_n, pbus_rst_n, host_rst_n};
    if (mon_en) begin
      for (int i = 0; i < 6; i++) begin
        if (cur[i] != prev[i]) begin
          if (q.size() == 0) begin
            check(1'b0, "R8 unexpected edge on output", i, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.idx == i && e.val == cur[i], {e.tag, " edge identity"}, i, e.idx);
            check(cyc >= e.lo && cyc <= e.hi, {e.tag, " edge time"}, cyc, e.lo);
          end
        end
      end
    end
    prev = cur;
  end

  task automatic drain(input string tag, input int limit);
    int n = 0;
    while (q.size() != 0 && n < limit) begin
      @(negedge clk); n++;
    end
    check(q.size() == 0, {tag, " all expected edges seen"}, q.size(), 0);
    q.delete();
  endtask

  task automatic power_up(input bit shrt, input string tag);
    int t0, p;
    @(negedge clk);
    rst_len_short = shrt;
    p = shrt ? PBS : PBL;
    t0 = cyc;
    pg_raw = 1'b1;
    expect_edge(5, 1'b1, t0 + DEB,              "R9 sleep release");
    expect_edge(3, 1'b1, t0 + DEB + NB,         "R5 bridge_pok rise");
    expect_edge(0, 1'b1, t0 + DEB + p - H,      "R3 host release");
    expect_edge(1, 1'b1, t0 + DEB + p,          shrt ? "R4 pbus release short" : "R4 pbus release long");
    expect_edge(2, 1'b1, t0 + DEB + p + PL,     "R3 link release");
    expect_edge(4, 1'b1, t0 + DEB + p + PL,     "R9 stop release");
    drain(tag, DEB + p + PL + 40);
  endtask

  task automatic power_down(input string tag);
    int t1;
    @(negedge clk);
    t1 = cyc;
    pg_raw = 1'b0;
    expect_edge(0, 1'b0, t1,           "R2 host assert");
    expect_edge(1, 1'b0, t1,           "R2 pbus assert");
    expect_edge(3, 1'b0, t1,           "R5 bridge_pok fall");
    expect_edge(4, 1'b0, t1,           "R7 stop assert");
    expect_edge(2, 1'b0, t1 + SL,      "R7 link assert");
    expect_edge(5, 1'b0, t1 + SL + SG, "R7 sleep assert");
    drain(tag, SL + SG + 40);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(host_rst_n == 0, "R8 reset host", host_rst_n, 0);
    check(pbus_rst_n == 0, "R8 reset pbus", pbus_rst_n, 0);
    check(link_rst_n == 0, "R8 reset link", link_rst_n, 0);
    check(bridge_pok == 0, "R8 reset bridge_pok", bridge_pok, 0);
    check(cpu_stop_n == 0, "R8 reset stop", cpu_stop_n, 0);
    check(sleep_n == 0,    "R8 reset sleep", sleep_n, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    // long reset up and down
    power_up(1'b0, "R4 long");
    repeat (20) @(negedge clk);
    power_down("R7 down1");
    repeat (10) @(negedge clk);

    // short reset
    power_up(1'b1, "R4 short");
    repeat (10) @(negedge clk);
    power_down("R7 down2");
    repeat (10) @(negedge clk);

    // R1 glitch shorter than the filter window
    pg_raw = 1'b1;
    repeat (DEB / 2) @(negedge clk);
    pg_raw = 1'b0;
    repeat (3) @(negedge clk);
    pg_raw = 1'b1;
    repeat (DEB / 2) @(negedge clk);
    pg_raw = 1'b0;
    repeat (10) @(negedge clk);
    check(sleep_n == 0 && host_rst_n == 0, "R1 glitch leaves outputs", sleep_n, 0);
    power_up(1'b1, "R1 after glitch");
    power_down("R7 down3");
    repeat (10) @(negedge clk);

    // R6 keyboard reset held across the release point
    begin
      int t0, tk;
      kbd_rst_n = 1'b0;
      @(negedge clk);
      rst_len_short = 1'b1;
      t0 = cyc;
      pg_raw = 1'b1;
      expect_edge(5, 1'b1, t0 + DEB,      "R9 sleep release kbd");
      expect_edge(3, 1'b1, t0 + DEB + NB, "R5 bridge_pok rise kbd");
      repeat (DEB + PBS + 30) @(negedge clk);
      check(host_rst_n == 0, "R6 host held by keyboard reset", host_rst_n, 0);
      check(pbus_rst_n == 0, "R6 pbus waits on host", pbus_rst_n, 0);
      tk = cyc;
      kbd_rst_n = 1'b1;
      expect_edge(0, 1'b1, tk,          "R6 host release after kbd");
      expect_edge(1, 1'b1, tk + H,      "R6 pbus follows host");
      expect_edge(2, 1'b1, tk + H + PL, "R6 link follows pbus");
      expect_edge(4, 1'b1, tk + H + PL, "R9 stop with link");
      drain("R6 kbd", 100);
    end
    power_down("R7 down4");

    repeat (20) @(negedge clk);
    check(q.size() == 0 && host_rst_n == 0 && link_rst_n == 0, "R2 resets stay asserted", host_rst_n, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule